// File: doc/BRIEF.md
# I2C Register Target with Pointer Auto-Increment

This block is an I2C target that gives a bus controller access to a bank of 8-bit registers. It answers one fixed 7-bit device address. A write transfer carries a register pointer and then any number of data bytes, and each byte lands one register above the one before it. A read transfer sets the pointer with a short write, then uses a repeated START and the device address with the read bit. The target then returns bytes from consecutive registers for as long as the controller acknowledges them.

Both bus lines pass through synchronisers into the system clock domain, and all bus decoding is done there on detected edges. SDA is open drain: the block only pulls it low or lets it go. A bus watchdog guards every transaction that is in progress. If no SCL edge arrives within a programmable number of system clocks, the watchdog drops the transaction, lets go of SDA and sets a sticky error flag. The flag and the watchdog's disable bit sit in a debug register inside the same bank, so the controller reaches them with ordinary transfers.

Top module: `i2c_reg_target`

## Requirements
- R1: After reset SDA is released, every data register reads 0x00, and the debug register reads 0x00 (watchdog enabled, no error flagged).
- R2: The target pulls SDA low in the ninth clock only when the first byte after a START matches its 7-bit address (MSB first, R/W in bit 0). Any other address gets no acknowledge, and the bytes that follow change no register.
- R3: In a write, the second byte sets the pointer and each later byte is stored at the pointer, which then steps up by one. Every byte is acknowledged.
- R4: The pointer steps from 0xFF to 0x00, in writes and in reads.
- R5: After a repeated START with the read bit, the target sends the register at the pointer MSB first. Each controller ACK makes it send the next register up.
- R6: A controller NACK after a read byte ends the read, and the target leaves SDA released.
- R7: A START or STOP that arrives before the eighth bit of a data byte abandons that byte, and no register is written. A START still begins a new transfer that keeps the pointer set so far.
- R8: While a transfer is open and the watchdog is enabled, a stretch of TIMEOUT_CYC system clocks with no SCL edge ends the transfer, releases SDA, and sets debug bit 0. Bit 0 then stays set.
- R9: Debug register (address DBG_ADDR) bit 2 is a disable for the watchdog and reads back as written. While bit 2 is 1, a stalled transfer is kept and SDA stays where it was. Writing the debug register with bit 0 = 1 clears the error flag.
- R10: SDA is only ever pulled low, and a new pull begins only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| sda_pull | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
The assertions assume that SCL and SDA change much more slowly than the system clock. Every level is taken to stay put for several clocks, so the synchronised SCL is already low when the target updates SDA. They also assume that the controller never moves SCL and SDA in the same system clock. The bench drives both lines on falling clock edges and holds each level for eight clocks per quarter bit, with SDA changing only mid-low-phase except at START and STOP. Watchdog stalls are the only places where SCL stops for longer than TIMEOUT_CYC.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEVADR,
        ST_DEVACK,
        ST_PTR,
        ST_PTRACK,
        ST_WDAT,
        ST_WDACK,
        ST_RDAT,
        ST_RDACK
    } tgt_state_e;

    typedef struct packed {
        logic [7:0] sh;
        logic [3:0] cnt;
    } rx_t;

    localparam logic [3:0] BITS_PER_BYTE = 4'd8;

    function automatic logic [7:0] dbg_pack(input logic dis, input logic sts);
        return {5'b0, dis, 1'b0, sts};
    endfunction

    function automatic logic addr_hit(input logic [7:0] b, input logic [6:0] dev);
        return b[7:1] == dev;
    endfunction

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dsync,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    genvar g;
    generate
        for (g = 0; g < W; g++) begin : g_line
            logic [STAGES-1:0] chain;
            logic              prev;
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain <= '1;
                    prev  <= 1'b1;
                end else begin
                    chain <= {chain[STAGES-2:0], din[g]};
                    prev  <= chain[STAGES-1];
                end
            end
            assign dsync[g] = chain[STAGES-1];
            assign rise[g]  = chain[STAGES-1] & ~prev;
            assign fall[g]  = ~chain[STAGES-1] & prev;
        end
    endgenerate
endmodule

// File: rtl/i2c_tgt_watchdog.sv
module i2c_tgt_watchdog #(
    parameter int TIMEOUT_CYC = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic kick,
    input  logic enable,
    output logic hit
);
    localparam int CW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_CYC);

    logic [CW-1:0] cnt;

    assign hit = active && enable && (cnt == LIMIT);

    always_ff @(posedge clk) begin
        if (rst || !active || kick || hit) begin
            cnt <= '0;
        end else if (cnt != LIMIT) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/i2c_tgt_regbank.sv
module i2c_tgt_regbank
    import i2c_tgt_pkg::*;
#(
    parameter int             PTR_W    = 8,
    parameter logic [PTR_W-1:0] DBG_ADDR = 8'h7E
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_addr,
    input  logic [7:0]       wr_data,
    input  logic [PTR_W-1:0] rd_addr,
    output logic [7:0]       rd_data,
    input  logic             err_set,
    output logic             det_en,
    output logic             err_sts,
    output logic             err_clr
);
    localparam int DEPTH = 1 << PTR_W;

    logic [7:0] mem [DEPTH];
    logic       det_dis;
    logic       dbg_wr;

    assign dbg_wr  = wr_en && (wr_addr == DBG_ADDR);
    assign err_clr = dbg_wr && wr_data[0];
    assign det_en  = !det_dis;
    assign rd_data = (rd_addr == DBG_ADDR) ? dbg_pack(det_dis, err_sts) : mem[rd_addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
        end else if (wr_en && !dbg_wr) begin
            mem[wr_addr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            det_dis <= 1'b0;
            err_sts <= 1'b0;
        end else begin
            if (dbg_wr) det_dis <= wr_data[2];
            if (err_set) err_sts <= 1'b1;
            else if (err_clr) err_sts <= 1'b0;
        end
    end
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h2A,
    parameter int         PTR_W       = 8,
    parameter logic [7:0] DBG_ADDR    = 8'h7E,
    parameter int         TIMEOUT_CYC = 1000,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_pull
);
    localparam logic [PTR_W-1:0] PTR_ONE = PTR_W'(1);

    logic [1:0] lv, lv_rise, lv_fall;
    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    i2c_tgt_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .din({sda_in, scl_in}),
        .dsync(lv), .rise(lv_rise), .fall(lv_fall)
    );

    assign scl_s     = lv[0];
    assign sda_s     = lv[1];
    assign scl_rise  = lv_rise[0];
    assign scl_fall  = lv_fall[0];
    assign start_det = lv_fall[1] & scl_s;
    assign stop_det  = lv_rise[1] & scl_s;

    tgt_state_e       st;
    rx_t              rx;
    logic [PTR_W-1:0] ptr;
    logic [7:0]       tx;
    logic             rw, mack;

    logic             bus_err, det_en, err_sts, err_clr;
    logic             wr_en, byte_end;
    logic [PTR_W-1:0] rd_addr;
    logic [7:0]       rd_data;

    i2c_tgt_watchdog #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_wdog (
        .clk(clk), .rst(rst),
        .active(st != ST_IDLE),
        .kick(scl_rise | scl_fall | start_det | stop_det),
        .enable(det_en),
        .hit(bus_err)
    );

    always_comb begin
        byte_end = scl_fall && (rx.cnt == BITS_PER_BYTE) && !bus_err && !start_det && !stop_det;
        wr_en    = byte_end && (st == ST_WDAT);
        rd_addr  = (st == ST_RDACK) ? ptr + PTR_ONE : ptr;
    end

    i2c_tgt_regbank #(.PTR_W(PTR_W), .DBG_ADDR(DBG_ADDR)) u_bank (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(ptr), .wr_data(rx.sh),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .err_set(bus_err), .det_en(det_en),
        .err_sts(err_sts), .err_clr(err_clr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            rx       <= '0;
            ptr      <= '0;
            tx       <= '0;
            rw       <= 1'b0;
            mack     <= 1'b0;
            sda_pull <= 1'b0;
        end else if (bus_err) begin
            st       <= ST_IDLE;
            sda_pull <= 1'b0;
        end else if (start_det) begin
            st       <= ST_DEVADR;
            rx.cnt   <= '0;
            sda_pull <= 1'b0;
        end else if (stop_det) begin
            st       <= ST_IDLE;
            sda_pull <= 1'b0;
        end else begin
            unique case (st)
                ST_DEVADR, ST_PTR, ST_WDAT: begin
                    if (scl_rise) begin
                        rx.sh  <= {rx.sh[6:0], sda_s};
                        rx.cnt <= rx.cnt + 1'b1;
                    end else if (byte_end) begin
                        rx.cnt <= '0;
                        if (st == ST_DEVADR) begin
                            if (addr_hit(rx.sh, DEV_ADDR)) begin
                                rw       <= rx.sh[0];
                                sda_pull <= 1'b1;
                                st       <= ST_DEVACK;
                            end else begin
                                st <= ST_IDLE;
                            end
                        end else if (st == ST_PTR) begin
                            ptr      <= rx.sh[PTR_W-1:0];
                            sda_pull <= 1'b1;
                            st       <= ST_PTRACK;
                        end else begin
                            sda_pull <= 1'b1;
                            st       <= ST_WDACK;
                        end
                    end
                end
                ST_DEVACK: begin
                    if (scl_fall) begin
                        if (rw) begin
                            tx       <= rd_data;
                            sda_pull <= ~rd_data[7];
                            rx.cnt   <= 4'd1;
                            st       <= ST_RDAT;
                        end else begin
                            sda_pull <= 1'b0;
                            st       <= ST_PTR;
                        end
                    end
                end
                ST_PTRACK: begin
                    if (scl_fall) begin
                        sda_pull <= 1'b0;
                        st       <= ST_WDAT;
                    end
                end
                ST_WDACK: begin
                    if (scl_fall) begin
                        sda_pull <= 1'b0;
                        ptr      <= ptr + PTR_ONE;
                        st       <= ST_WDAT;
                    end
                end
                ST_RDAT: begin
                    if (scl_fall) begin
                        if (rx.cnt == BITS_PER_BYTE) begin
                            sda_pull <= 1'b0;
                            rx.cnt   <= '0;
                            st       <= ST_RDACK;
                        end else begin
                            sda_pull <= ~tx[6];
                            tx       <= {tx[6:0], 1'b0};
                            rx.cnt   <= rx.cnt + 1'b1;
                        end
                    end
                end
                ST_RDACK: begin
                    if (scl_rise) begin
                        mack <= ~sda_s;
                    end else if (scl_fall) begin
                        if (mack) begin
                            ptr      <= rd_addr;
                            tx       <= rd_data;
                            sda_pull <= ~rd_data[7];
                            rx.cnt   <= 4'd1;
                            st       <= ST_RDAT;
                        end else begin
                            sda_pull <= 1'b0;
                            st       <= ST_IDLE;
                        end
                    end
                end
                default: begin
                    sda_pull <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/i2c_reg_target_chk.sv
module i2c_reg_target_chk
    import i2c_tgt_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       scl_s,
    input logic       sda_pull,
    input tgt_state_e st,
    input logic       bus_err,
    input logic       err_sts,
    input logic       err_clr,
    input logic       det_en,
    input logic [3:0] cnt
);
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE) |-> !sda_pull); // R1

    AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_pull) |-> !scl_s); // R10

    AST_ERR_RELEASE: assert property (@(posedge clk) disable iff (rst)
        bus_err |=> (st == ST_IDLE) && !sda_pull); // R8

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
        (err_sts && !err_clr) |=> err_sts); // R8

    AST_ERR_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
        bus_err |=> err_sts); // R8

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
        !det_en |-> !bus_err); // R9

    AST_BITCNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt <= 4'd8); // R3
endmodule

bind i2c_reg_target i2c_reg_target_chk u_chk (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_pull(sda_pull), .st(st),
    .bus_err(bus_err), .err_sts(err_sts), .err_clr(err_clr),
    .det_en(det_en), .cnt(rx.cnt)
);

// File: tb/tb_i2c_reg_target.sv
module tb_i2c_reg_target;
    localparam logic [6:0] DEV = 7'h2A;
    localparam logic [7:0] DBG = 8'h7E;
    localparam int Q = 8;
    localparam int STALL = 1500;
    localparam int NV = 6;
    localparam logic [15:0] VEC [NV] = '{16'h05A5, 16'h063C, 16'h4000,
                                         16'h41FF, 16'hC081, 16'h107E};

    logic clk = 1'b0, rst = 1'b1;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic sda_pull, sda_line;
    int n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;
    assign sda_line = sda_m & ~sda_pull;

    i2c_reg_target dut (.clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_line), .sda_pull(sda_pull));

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic hold(); repeat (Q) @(negedge clk); endtask
    task automatic start_c(); sda_m = 1; hold(); scl_m = 1; hold(); sda_m = 0; hold(); scl_m = 0; hold(); endtask
    task automatic stop_c(); sda_m = 0; hold(); scl_m = 1; hold(); sda_m = 1; hold(); endtask
    task automatic bit_w(input logic b); sda_m = b; hold(); scl_m = 1; hold(); hold(); scl_m = 0; hold(); endtask
    task automatic bit_r(output logic r); sda_m = 1; hold(); scl_m = 1; hold(); r = sda_line; hold(); scl_m = 0; hold(); endtask

    task automatic byte_w(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) bit_w(d[i]);
        bit_r(b);
        ack = ~b;
    endtask

    task automatic byte_r(input logic mack, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) bit_r(d[i]);
        bit_w(~mack);
    endtask

    task automatic wr1(input logic [7:0] p, input logic [7:0] d);
        logic a;
        start_c(); byte_w({DEV, 1'b0}, a); byte_w(p, a); byte_w(d, a); stop_c();
    endtask

    task automatic rd_setup(input logic [7:0] p);
        logic a;
        start_c(); byte_w({DEV, 1'b0}, a); byte_w(p, a);
        start_c(); byte_w({DEV, 1'b1}, a);
    endtask

    task automatic rd1(input logic [7:0] p, output logic [7:0] d);
        rd_setup(p); byte_r(1'b0, d); stop_c();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic a;
        repeat (5) @(negedge clk);
        rst = 0;
        repeat (5) @(negedge clk);

        // R1 reset state
        chk("R1 sda released", {7'b0, sda_line}, 8'h01);
        rd1(8'h05, d); chk("R1 data reg", d, 8'h00);
        rd1(DBG, d);   chk("R1 debug reg", d, 8'h00);

        // table walk: R3 single writes, R5 single reads
        for (int i = 0; i < NV; i++) wr1(VEC[i][15:8], VEC[i][7:0]);
        for (int i = 0; i < NV; i++) begin
            rd1(VEC[i][15:8], d);
            chk("R3/R5 table", d, VEC[i][7:0]);
        end

        // R2 address acknowledge and mismatch
        start_c(); byte_w({DEV, 1'b0}, a); chk("R2 ack own addr", {7'b0, a}, 8'h01); stop_c();
        start_c(); byte_w({7'h11, 1'b0}, a); chk("R2 no ack other", {7'b0, a}, 8'h00);
        byte_w(8'h05, a); byte_w(8'h99, a); stop_c();
        rd1(8'h05, d); chk("R2 mismatch no write", d, 8'hA5);

        // R3 auto-increment write, R5 ACK-driven read chain
        start_c(); byte_w({DEV, 1'b0}, a); byte_w(8'h30, a);
        byte_w(8'h11, a); byte_w(8'h22, a); byte_w(8'h33, a);
        chk("R3 data ack", {7'b0, a}, 8'h01); stop_c();
        rd_setup(8'h30);
        byte_r(1'b1, d); chk("R5 burst 0", d, 8'h11);
        byte_r(1'b1, d); chk("R5 burst 1", d, 8'h22);
        byte_r(1'b0, d); chk("R5 burst 2", d, 8'h33);
        chk("R6 released after nack", {7'b0, sda_line}, 8'h01);
        stop_c();

        // R4 wrap in write and read
        start_c(); byte_w({DEV, 1'b0}, a); byte_w(8'hFF, a);
        byte_w(8'h5A, a); byte_w(8'h6B, a); stop_c();
        rd_setup(8'hFF);
        byte_r(1'b1, d); chk("R4 reg FF", d, 8'h5A);
        byte_r(1'b0, d); chk("R4 wrap to 00", d, 8'h6B);
        stop_c();

        // R7 STOP mid-byte
        start_c(); byte_w({DEV, 1'b0}, a); byte_w(8'h06, a);
        bit_w(1'b0); bit_w(1'b1); bit_w(1'b0); bit_w(1'b1); stop_c();
        rd1(8'h06, d); chk("R7 stop abort", d, 8'h3C);
        // R7 START mid-byte, pointer kept
        start_c(); byte_w({DEV, 1'b0}, a); byte_w(8'h41, a);
        bit_w(1'b0); bit_w(1'b0); bit_w(1'b0);
        start_c(); byte_w({DEV, 1'b1}, a); byte_r(1'b0, d); stop_c();
        chk("R7 start abort", d, 8'hFF);

        // R8 watchdog releases a hung read
        wr1(8'h20, 8'h12);
        rd_setup(8'h20);
        chk("R8 driving before stall", {7'b0, sda_line}, 8'h00);
        repeat (STALL) @(negedge clk);
        chk("R8 released after timeout", {7'b0, sda_line}, 8'h01);
        stop_c();
        rd1(DBG, d); chk("R8 flag set", d, 8'h01);
        rd1(DBG, d); chk("R8 flag sticky", d, 8'h01);

        // R9 clear and disable
        wr1(DBG, 8'h01);
        rd1(DBG, d); chk("R9 flag cleared", d, 8'h00);
        wr1(DBG, 8'h04);
        rd1(DBG, d); chk("R9 disable reads back", d, 8'h04);
        rd_setup(8'h20);
        repeat (STALL) @(negedge clk);
        chk("R9 held while disabled", {7'b0, sda_line}, 8'h00);
        byte_r(1'b0, d); chk("R9 transfer survives", d, 8'h12);
        stop_c();
        rd1(DBG, d); chk("R9 no flag when disabled", d, 8'h04);
        wr1(DBG, 8'h00);
        rd1(DBG, d); chk("R9 re-enabled", d, 8'h00);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule